// File: doc/BRIEF.md
# Snooping Bus Coherence Controller

This block keeps the coherence state for one cache attached to a shared snooping bus. A small direct-mapped table holds a tag and one of three states for each line: not present, exclusive (the only cached copy, writable without telling anyone), or shared (other caches may hold copies). Local processor reads and writes are looked up in the table. Hits that need no permission finish at once. Other accesses win a bus slot through a request/grant handshake and issue either a plain read or a read-for-ownership.

In parallel the controller watches every bus transaction placed by other caches. A foreign plain read that hits a valid local line makes the controller drive the wired shared response and demote the line to shared. A foreign read-for-ownership removes the local copy. A requester fills a read miss as exclusive or shared, depending on whether any other cache raised the shared response during its bus read. Writes always end with the line held exclusive, so all write coherence traffic is ownership requests; no updated values are broadcast. Line data, memory and bus arbitration sit outside this block.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is not present, and `cpu_done`, `bus_req` and `snp_shared` are low; the first read of any address therefore goes to the bus.
- R2: A read that misses raises `bus_req` with `bus_cmd` = 1 (plain read). The line fills as exclusive (`cpu_st` = 01) if `bus_shr_in` is low in the grant cycle, and as shared (`cpu_st` = 10) if it is high.
- R3: A read that hits an exclusive or shared line raises `cpu_done` for one cycle, the cycle after the request is accepted, with no bus request. `cpu_st` reports the unchanged state.
- R4: A write to a line held exclusive finishes locally with no bus request, and the line stays exclusive.
- R5: A write to a shared line or to a missing line issues `bus_cmd` = 2 (read-for-ownership). The line becomes exclusive, and `cpu_done` rises in the cycle after the grant.
- R6: While `bus_req` waits for `bus_gnt`, it stays high with `bus_cmd` and `bus_addr` stable. Only one bus transaction is outstanding, and `cpu_done` is never high together with `bus_req`.
- R7: A snooped plain read (`snp_cmd` = 1) from another source that hits a present line drives `snp_shared` high in that same cycle, and an exclusive line becomes shared.
- R8: A snooped read-for-ownership (`snp_cmd` = 2) from another source that hits a present line makes it not present, and `snp_shared` stays low.
- R9: A snooped transaction whose `snp_src` equals the local ID has no effect: no shared response and no state change.
- R10: A snooped transaction whose tag differs from the stored tag at that index has no effect on that line and gives no shared response.
- R11: A processor request is not accepted in a cycle where a foreign snoop targets the same index. The snoop is applied first, and the request is decided on the updated state.
- R12: A miss to an index that holds a different tag replaces that line. Afterwards the old address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | LINE_AW | Line address (low IDX_W bits index, rest tag) |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_st | output | 2 | Line state after the access (00 none, 01 exclusive, 10 shared) |
| bus_req | output | 1 | Bus request, held until granted |
| bus_gnt | input | 1 | Grant; the transaction happens in the grant cycle |
| bus_cmd | output | 2 | 1 = plain read, 2 = read-for-ownership |
| bus_addr | output | LINE_AW | Line address of the local transaction |
| bus_src | output | SRC_W | Local cache ID |
| bus_shr_in | input | 1 | Wired shared response sampled in the grant cycle |
| snp_valid | input | 1 | A bus transaction is visible for snooping |
| snp_cmd | input | 2 | Snooped command (1 read, 2 read-for-ownership) |
| snp_addr | input | LINE_AW | Snooped line address |
| snp_src | input | SRC_W | ID of the issuing cache |
| snp_shared | output | 1 | Shared response, combinational in the snoop cycle |

## Verification
A wrong line state never shows up as a value directly. It shows up in how the next local access to that line behaves. A stale exclusive state lets a write finish without a bus request. A lost exclusive or shared state makes a read go to the bus when it should have hit. A wrong demotion gives the wrong `cpu_st` on the next hit. The exception is snoop state, which shows up at once as a wrong `snp_shared` level in the snoop cycle. So every snoop scenario is followed by a local read or write of the same line, and the bus activity and reported state are checked within the few cycles that access takes.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LS_NONE = 2'b00,
        LS_EXCL = 2'b01,
        LS_SHRD = 2'b10
    } line_st_e;

    typedef enum logic [1:0] {
        BC_IDLE  = 2'b00,
        BC_READ  = 2'b01,
        BC_READX = 2'b10
    } bus_cmd_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'b00,
        FS_BUS  = 2'b01,
        FS_RESP = 2'b10
    } fsm_st_e;

    // State a present line takes after a foreign transaction hits it.
    function automatic line_st_e snoop_next(line_st_e cur, bus_cmd_e cmd);
        line_st_e nxt;
        nxt = cur;
        if (cmd == BC_READX)
            nxt = LS_NONE;
        else if (cmd == BC_READ && cur != LS_NONE)
            nxt = LS_SHRD;
        return nxt;
    endfunction

    // State a line is filled with when the local bus transaction completes.
    function automatic line_st_e fill_state(logic is_write, logic others_share);
        line_st_e s;
        if (is_write)
            s = LS_EXCL;
        else if (others_share)
            s = LS_SHRD;
        else
            s = LS_EXCL;
        return s;
    endfunction

endpackage

// File: rtl/coh_tag_array.sv
module coh_tag_array
    import coh_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] a_idx,
    output line_st_e         a_st,
    output logic [TAG_W-1:0] a_tag,
    input  logic [IDX_W-1:0] b_idx,
    output line_st_e         b_st,
    output logic [TAG_W-1:0] b_tag,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  line_st_e         fill_st,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  line_st_e         upd_st
);
    localparam int DEPTH = 1 << IDX_W;

    line_st_e         st_w  [DEPTH];
    logic [TAG_W-1:0] tag_w [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        line_st_e         st_q;
        logic [TAG_W-1:0] tag_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q  <= LS_NONE;
                tag_q <= '0;
            end else if (fill_en && fill_idx == IDX_W'(i)) begin
                st_q  <= fill_st;
                tag_q <= fill_tag;
            end else if (upd_en && upd_idx == IDX_W'(i)) begin
                st_q  <= upd_st;
            end
        end

        assign st_w[i]  = st_q;
        assign tag_w[i] = tag_q;
    end

    assign a_st  = st_w[a_idx];
    assign a_tag = tag_w[a_idx];
    assign b_st  = st_w[b_idx];
    assign b_tag = tag_w[b_idx];

endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
    import coh_pkg::*;
#(
    parameter int TAG_W    = 7,
    parameter int SRC_W    = 2,
    parameter int LOCAL_ID = 1
) (
    input  logic             snp_valid,
    input  bus_cmd_e         snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [SRC_W-1:0] snp_src,
    input  line_st_e         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             active,
    output logic             shared,
    output logic             upd_en,
    output line_st_e         upd_st
);
    logic hit;

    always_comb begin
        active = snp_valid && (snp_src != SRC_W'(LOCAL_ID)) && (snp_cmd != BC_IDLE);
        hit    = active && (line_st != LS_NONE) && (line_tag == snp_tag);
        upd_en = hit;
        upd_st = snoop_next(line_st, snp_cmd);
        shared = hit && (snp_cmd == BC_READ);
    end

endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
    import coh_pkg::*;
#(
    parameter int LINE_AW = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_valid,
    input  logic               cpu_we,
    input  logic [LINE_AW-1:0] cpu_addr,
    input  line_st_e           look_st,
    input  logic               blocked,
    input  logic               bus_gnt,
    input  logic               bus_shr_in,
    output logic               cpu_done,
    output line_st_e           rsp_st,
    output logic               bus_req,
    output bus_cmd_e           bus_cmd,
    output logic [LINE_AW-1:0] op_addr,
    output logic               fill_en,
    output line_st_e           fill_st,
    output logic               idle
);
    fsm_st_e            fsm_q;
    logic               op_we_q;
    logic [LINE_AW-1:0] op_addr_q;
    line_st_e           rsp_q;
    logic               local_ok;

    always_comb begin
        local_ok = (look_st == LS_EXCL) || (look_st == LS_SHRD && !cpu_we);
        idle     = (fsm_q == FS_IDLE);
        bus_req  = (fsm_q == FS_BUS);
        bus_cmd  = bus_req ? (op_we_q ? BC_READX : BC_READ) : BC_IDLE;
        fill_en  = bus_req && bus_gnt;
        fill_st  = fill_state(op_we_q, bus_shr_in);
        cpu_done = (fsm_q == FS_RESP);
        rsp_st   = rsp_q;
        op_addr  = op_addr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q     <= FS_IDLE;
            op_we_q   <= 1'b0;
            op_addr_q <= '0;
            rsp_q     <= LS_NONE;
        end else begin
            case (fsm_q)
                FS_IDLE: begin
                    if (cpu_valid && !blocked) begin
                        op_we_q   <= cpu_we;
                        op_addr_q <= cpu_addr;
                        if (local_ok) begin
                            rsp_q <= look_st;
                            fsm_q <= FS_RESP;
                        end else begin
                            fsm_q <= FS_BUS;
                        end
                    end
                end
                FS_BUS: begin
                    if (bus_gnt) begin
                        rsp_q <= fill_st;
                        fsm_q <= FS_RESP;
                    end
                end
                default: fsm_q <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
    import coh_pkg::*;
#(
    parameter int LINE_AW  = 10,
    parameter int IDX_W    = 3,
    parameter int SRC_W    = 2,
    parameter int LOCAL_ID = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_valid,
    input  logic               cpu_we,
    input  logic [LINE_AW-1:0] cpu_addr,
    output logic               cpu_done,
    output logic [1:0]         cpu_st,
    output logic               bus_req,
    input  logic               bus_gnt,
    output logic [1:0]         bus_cmd,
    output logic [LINE_AW-1:0] bus_addr,
    output logic [SRC_W-1:0]   bus_src,
    input  logic               bus_shr_in,
    input  logic               snp_valid,
    input  logic [1:0]         snp_cmd,
    input  logic [LINE_AW-1:0] snp_addr,
    input  logic [SRC_W-1:0]   snp_src,
    output logic               snp_shared
);
    localparam int TAG_W = LINE_AW - IDX_W;

    logic [IDX_W-1:0]   cpu_idx, snp_idx, fill_idx;
    logic [TAG_W-1:0]   cpu_tag, snp_tag, fill_tag;
    line_st_e           a_st, b_st, look_st, upd_st, fill_st, rsp_st;
    logic [TAG_W-1:0]   a_tag, b_tag;
    logic               snp_act, upd_en, fill_en, blocked, fsm_idle;
    bus_cmd_e           cmd_e;
    logic [LINE_AW-1:0] op_addr;

    always_comb begin
        cpu_idx  = cpu_addr[IDX_W-1:0];
        cpu_tag  = cpu_addr[LINE_AW-1:IDX_W];
        snp_idx  = snp_addr[IDX_W-1:0];
        snp_tag  = snp_addr[LINE_AW-1:IDX_W];
        fill_idx = op_addr[IDX_W-1:0];
        fill_tag = op_addr[LINE_AW-1:IDX_W];
        look_st  = (a_tag == cpu_tag) ? a_st : LS_NONE;
        blocked  = snp_act && (snp_idx == cpu_idx);
    end

    coh_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .a_idx    (cpu_idx),
        .a_st     (a_st),
        .a_tag    (a_tag),
        .b_idx    (snp_idx),
        .b_st     (b_st),
        .b_tag    (b_tag),
        .fill_en  (fill_en),
        .fill_idx (fill_idx),
        .fill_tag (fill_tag),
        .fill_st  (fill_st),
        .upd_en   (upd_en),
        .upd_idx  (snp_idx),
        .upd_st   (upd_st)
    );

    coh_snoop #(.TAG_W(TAG_W), .SRC_W(SRC_W), .LOCAL_ID(LOCAL_ID)) u_snoop (
        .snp_valid (snp_valid),
        .snp_cmd   (bus_cmd_e'(snp_cmd)),
        .snp_tag   (snp_tag),
        .snp_src   (snp_src),
        .line_st   (b_st),
        .line_tag  (b_tag),
        .active    (snp_act),
        .shared    (snp_shared),
        .upd_en    (upd_en),
        .upd_st    (upd_st)
    );

    coh_req_fsm #(.LINE_AW(LINE_AW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cpu_valid  (cpu_valid),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .look_st    (look_st),
        .blocked    (blocked),
        .bus_gnt    (bus_gnt),
        .bus_shr_in (bus_shr_in),
        .cpu_done   (cpu_done),
        .rsp_st     (rsp_st),
        .bus_req    (bus_req),
        .bus_cmd    (cmd_e),
        .op_addr    (op_addr),
        .fill_en    (fill_en),
        .fill_st    (fill_st),
        .idle       (fsm_idle)
    );

    assign cpu_st   = fsm_idle ? 2'b00 : rsp_st;
    assign bus_cmd  = cmd_e;
    assign bus_addr = op_addr;
    assign bus_src  = SRC_W'(LOCAL_ID);

endmodule

// File: rtl/coh_checker.sv
module coh_checker #(
    parameter int LINE_AW  = 10,
    parameter int SRC_W    = 2,
    parameter int LOCAL_ID = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               cpu_done,
    input logic [1:0]         cpu_st,
    input logic               bus_req,
    input logic               bus_gnt,
    input logic [1:0]         bus_cmd,
    input logic [LINE_AW-1:0] bus_addr,
    input logic               snp_valid,
    input logic [1:0]         snp_cmd,
    input logic [SRC_W-1:0]   snp_src,
    input logic               snp_shared
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_gnt |=> bus_req && $stable(bus_cmd) && $stable(bus_addr)); // R6

    AST_NO_REQ_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !cpu_done); // R6

    AST_DONE_AFTER_GNT: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_gnt |=> cpu_done); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done); // R3

    AST_DONE_PRESENT: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> cpu_st != 2'b00); // R2

    AST_OWN_SNOOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        snp_valid && snp_src == SRC_W'(LOCAL_ID) |-> !snp_shared); // R9

    AST_READX_NO_SHARE: assert property (@(posedge clk) disable iff (rst)
        snp_valid && snp_cmd == 2'd2 |-> !snp_shared); // R8

endmodule

bind snoop_coh_ctrl coh_checker #(
    .LINE_AW(LINE_AW), .SRC_W(SRC_W), .LOCAL_ID(LOCAL_ID)
) u_coh_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_done   (cpu_done),
    .cpu_st     (cpu_st),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .snp_src    (snp_src),
    .snp_shared (snp_shared)
);

// File: tb/tb_snoop_coh_ctrl.sv
module tb_snoop_coh_ctrl;
    localparam int LINE_AW = 10;
    localparam int SRC_W   = 2;
    localparam int MY_ID   = 1;

    logic clk = 0, rst = 1;
    logic cpu_valid = 0, cpu_we = 0;
    logic [LINE_AW-1:0] cpu_addr = '0;
    logic cpu_done;
    logic [1:0] cpu_st;
    logic bus_req, bus_gnt = 0, bus_shr_in = 0;
    logic [1:0] bus_cmd;
    logic [LINE_AW-1:0] bus_addr;
    logic [SRC_W-1:0] bus_src;
    logic snp_valid = 0;
    logic [1:0] snp_cmd = 0;
    logic [LINE_AW-1:0] snp_addr = '0;
    logic [SRC_W-1:0] snp_src = 0;
    logic snp_shared;

    int n_chk = 0, n_bad = 0, cyc = 0;

    localparam logic [LINE_AW-1:0] A = 10'h011, B = 10'h022, C = 10'h033;
    localparam logic [LINE_AW-1:0] D = 10'h0C3, E = 10'h045;

    always #10 clk = ~clk;

    snoop_coh_ctrl #(.LINE_AW(LINE_AW), .IDX_W(3), .SRC_W(SRC_W), .LOCAL_ID(MY_ID)) dut (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_done(cpu_done), .cpu_st(cpu_st), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_src(bus_src), .bus_shr_in(bus_shr_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_src(snp_src),
        .snp_shared(snp_shared)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            summary();
        end
    end

    task automatic cpu_start(input bit we, input logic [LINE_AW-1:0] addr);
        @(negedge clk);
        cpu_valid = 1; cpu_we = we; cpu_addr = addr;
    endtask

    // Runs the access to completion, granting after 'delay' waiting cycles.
    task automatic cpu_finish(input bit shr, input int delay,
                              output bit got_bus, output int cmd, output int st,
                              output int req_cyc, output bit addr_moved);
        bit fin = 0;
        logic [LINE_AW-1:0] a0 = '0;
        got_bus = 0; cmd = 0; st = 0; req_cyc = 0; addr_moved = 0;
        while (!fin) begin
            @(negedge clk);
            bus_gnt = 0;
            if (cpu_done) begin
                st = int'(cpu_st);
                cpu_valid = 0;
                fin = 1;
            end else if (bus_req) begin
                if (!got_bus) a0 = bus_addr;
                else if (bus_addr != a0) addr_moved = 1;
                got_bus = 1;
                cmd = int'(bus_cmd);
                req_cyc++;
                if (req_cyc > delay) begin
                    bus_gnt = 1;
                    bus_shr_in = shr;
                end
            end
        end
    endtask

    task automatic access(input bit we, input logic [LINE_AW-1:0] addr, input bit shr,
                          output bit got_bus, output int cmd, output int st);
        int rc; bit mv;
        cpu_start(we, addr);
        cpu_finish(shr, 0, got_bus, cmd, st, rc, mv);
    endtask

    // Drives one foreign-visible snoop cycle and returns the shared response.
    task automatic snoop(input int cmd, input logic [LINE_AW-1:0] addr, input int src,
                         output bit shr);
        @(negedge clk);
        snp_valid = 1; snp_cmd = 2'(cmd); snp_addr = addr; snp_src = SRC_W'(src);
        #1 shr = snp_shared;
        @(negedge clk);
        snp_valid = 0;
    endtask

    task automatic t_reset();
        bit gb; int cm, st;
        chk(!cpu_done && !bus_req && !snp_shared, "R1 idle outputs", int'(bus_req), 0);
        access(0, E, 0, gb, cm, st);
        chk(gb, "R1 first read goes to bus", int'(gb), 1);
    endtask

    task automatic t_read_miss();
        bit gb; int cm, st;
        access(0, A, 0, gb, cm, st);
        chk(gb && cm == 1, "R2 read miss cmd", cm, 1);
        chk(st == 1, "R2 fill exclusive", st, 1);
        access(0, B, 1, gb, cm, st);
        chk(st == 2, "R2 fill shared", st, 2);
    endtask

    task automatic t_read_hit();
        bit gb; int cm, st;
        access(0, A, 0, gb, cm, st);
        chk(!gb, "R3 read hit no bus", int'(gb), 0);
        chk(st == 1, "R3 read hit state", st, 1);
    endtask

    task automatic t_write_excl();
        bit gb; int cm, st;
        access(1, A, 0, gb, cm, st);
        chk(!gb, "R4 silent write", int'(gb), 0);
        chk(st == 1, "R4 stays exclusive", st, 1);
    endtask

    task automatic t_write_upgrade();
        bit gb; int cm, st;
        access(1, B, 1, gb, cm, st);
        chk(gb && cm == 2, "R5 shared write readx", cm, 2);
        chk(st == 1, "R5 shared write ends exclusive", st, 1);
        access(1, C, 1, gb, cm, st);
        chk(gb && cm == 2, "R5 write miss readx", cm, 2);
        chk(st == 1, "R5 write miss exclusive", st, 1);
    endtask

    task automatic t_handshake();
        bit gb, mv; int cm, st, rc;
        cpu_start(1, 10'h0E5);
        cpu_finish(0, 3, gb, cm, st, rc, mv);
        chk(rc == 4, "R6 req held until grant", rc, 4);
        chk(!mv, "R6 addr stable while waiting", int'(mv), 0);
        chk(st == 1, "R6 completes after grant", st, 1);
    endtask

    task automatic t_snoop_read();
        bit gb, sh; int cm, st;
        snoop(1, A, 2, sh);
        chk(sh, "R7 shared response", int'(sh), 1);
        access(0, A, 0, gb, cm, st);
        chk(!gb && st == 2, "R7 exclusive demoted to shared", st, 2);
    endtask

    task automatic t_snoop_readx();
        bit gb, sh; int cm, st;
        snoop(2, C, 0, sh);
        chk(!sh, "R8 no shared on readx", int'(sh), 0);
        access(0, C, 0, gb, cm, st);
        chk(gb, "R8 line invalidated", int'(gb), 1);
    endtask

    task automatic t_self_snoop();
        bit gb, sh; int cm, st;
        snoop(2, C, MY_ID, sh);
        chk(!sh, "R9 own readx quiet", int'(sh), 0);
        snoop(1, C, MY_ID, sh);
        chk(!sh, "R9 own read quiet", int'(sh), 0);
        access(0, C, 0, gb, cm, st);
        chk(!gb && st == 1, "R9 state unchanged", st, 1);
    endtask

    task automatic t_tag_mismatch();
        bit gb, sh; int cm, st;
        snoop(1, D, 2, sh);
        chk(!sh, "R10 mismatch no shared", int'(sh), 0);
        snoop(2, D, 2, sh);
        access(0, C, 0, gb, cm, st);
        chk(!gb && st == 1, "R10 line untouched", st, 1);
    endtask

    task automatic t_conflict();
        bit gb, mv; int cm, st, rc;
        @(negedge clk);
        cpu_valid = 1; cpu_we = 1; cpu_addr = C;
        snp_valid = 1; snp_cmd = 2; snp_addr = C; snp_src = 3;
        @(negedge clk);
        snp_valid = 0;
        cpu_finish(0, 0, gb, cm, st, rc, mv);
        chk(gb && cm == 2, "R11 snoop wins, write needs bus", cm, 2);
    endtask

    task automatic t_replace();
        bit gb; int cm, st;
        access(0, D, 0, gb, cm, st);
        chk(gb && st == 1, "R12 new tag filled", st, 1);
        access(0, C, 0, gb, cm, st);
        chk(gb, "R12 old tag misses", int'(gb), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_read_miss();
        t_read_hit();
        t_write_excl();
        t_write_upgrade();
        t_handshake();
        t_snoop_read();
        t_snoop_readx();
        t_self_snoop();
        t_tag_mismatch();
        t_conflict();
        t_replace();
        repeat (3) @(negedge clk);
        summary();
    end
endmodule